// File: doc/BRIEF.md
# Keyed Watchdog Timer with Pre-Warning

This block is a watchdog for a system-on-chip. Software talks to it through a small 16-bit register window with a one-cycle write strobe and a combinational read port. Every control action is guarded by a 16-bit magic value: a wrong value is simply dropped. Once fed, the timer counts down a 15-bit timeout, one unit per cycle in which the `tick_en` input is high (that input is the 10 ms tick taken from a slow clock). The tick that brings the count to zero raises a warning interrupt event. The next tick fires a one-cycle reset pulse, records a sticky timeout status and reloads the counter from the timeout register.

Turning the timer off takes two ordered keyed writes, so stray code cannot silence it. A debug-mode input freezes the countdown unless software has asked for the watchdog to keep running during debug. The control sequencer has three states. `ST_OFF` is disabled with the counter frozen. `ST_READY` is enabled and waiting for a feed. `ST_RUN` is counting.

The transitions are:
- restart (`ST_OFF` to `ST_READY`, on the restart key)
- start (`ST_READY` to `ST_RUN`, on the feed key)
- refeed (`ST_RUN` to `ST_RUN` with a reload, on the feed key)
- expire (`ST_RUN` to `ST_RUN` with a reload, on the tick at count zero)
- shutdown (`ST_READY` or `ST_RUN` to `ST_OFF`, on the armed second disable key)

Top module: `keyed_wdog`

## Requirements
- R1: After `rst_n` low, the block is in `ST_OFF`. The timeout register reads the parameter default (6000 = 0x1770). The count reads 0 and the status reads 0x0000. Event and mask read 0, and `irq` and `wdog_rst` are low. The register offsets are: feed 0x00, timeout 0x04, disable-1 0x08, disable-2 0x0C, status 0x10, count 0x14, debug 0x18, restart 0x1C, event 0x20, mask 0x24, force 0x28.
- R2: A write to 0x04 stores `wdata[14:0]`, and a read of 0x04 returns it with bit 15 zero, so 0xFFFF reads back as 0x7FFF.
- R3: Writing 0xACED to 0x1C moves `ST_OFF` to `ST_READY`; other values are ignored. Reading 0x0C gives 0xDABE in `ST_OFF` and 0x0000 otherwise.
- R4: Writing 0xFEED to 0x00 in `ST_READY` or `ST_RUN` loads the counter from the timeout register and enters `ST_RUN`. Other values, or any value written in `ST_OFF`, leave the count unchanged.
- R5: Writing 0xCAFE to 0x0C enters `ST_OFF` only when the write immediately before it was 0x0BAD to 0x08. Any other write in between cancels the arming. In `ST_OFF` the counter holds its value through ticks.
- R6: In `ST_RUN`, each cycle with `tick_en` high decrements the counter. Reading 0x14 gives the count in bits 14:0. Bit 15 is 1 in the cycle right after the counter changed, and 0 otherwise.
- R7: The tick that takes the count from 1 to 0 sets the event (bit 0 of 0x20). The following tick drives `wdog_rst` high for exactly one cycle and reloads the count from the timeout register.
- R8: An expiry makes 0x10 read 0xCFE8. Writing 0xE8B4 to 0x10 returns it to 0x0000, and other values are ignored. Nothing else clears it except `rst_n`.
- R9: `irq` is the event bit ANDed with bit 0 of 0x24. Writing 1 in bit 0 of 0x20 clears the event, and writing 1 in bit 0 of 0x28 sets it.
- R10: Reading 0x18 gives `dbg_mode` in bit 1 and a keep-running bit in bit 0, which is written through bit 0. While `dbg_mode` is high and the keep bit is 0, ticks do not decrement the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, the only clear of the status |
| tick_en | input | 1 | One-cycle 10 ms tick strobe |
| dbg_mode | input | 1 | High while the debugger holds the system |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Warning interrupt, masked |
| wdog_rst | output | 1 | One-cycle reset pulse on expiry |

## Verification
Every register write, tick and key acts on the clock edge that samples it. The count, the update flag, the event, `irq`, the status and `wdog_rst` therefore all show the result one edge later. Reads are combinational from `bus_addr`, with no added latency. The bench drives each stimulus half a cycle before an edge and samples at the following falling edge. That is where the update flag is expected to be 1. Each read then uses up one more cycle, so a second read of the count shows the flag back at 0, and `wdog_rst` is checked high at the first falling edge after the expiring tick and low at the next one.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_READY, ST_RUN} wd_state_e;

    localparam int AW = 6;
    localparam int DW = 16;

    localparam logic [AW-1:0] A_FEED  = 6'h00;
    localparam logic [AW-1:0] A_TMO   = 6'h04;
    localparam logic [AW-1:0] A_DIS1  = 6'h08;
    localparam logic [AW-1:0] A_DIS2  = 6'h0C;
    localparam logic [AW-1:0] A_STAT  = 6'h10;
    localparam logic [AW-1:0] A_CNT   = 6'h14;
    localparam logic [AW-1:0] A_DBG   = 6'h18;
    localparam logic [AW-1:0] A_RSTRT = 6'h1C;
    localparam logic [AW-1:0] A_EVT   = 6'h20;
    localparam logic [AW-1:0] A_MASK  = 6'h24;
    localparam logic [AW-1:0] A_FORCE = 6'h28;

    localparam logic [DW-1:0] K_FEED   = 16'hFEED;
    localparam logic [DW-1:0] K_DIS1   = 16'h0BAD;
    localparam logic [DW-1:0] K_DIS2   = 16'hCAFE;
    localparam logic [DW-1:0] K_RSTRT  = 16'hACED;
    localparam logic [DW-1:0] K_SCLR   = 16'hE8B4;
    localparam logic [DW-1:0] V_OFF    = 16'hDABE;
    localparam logic [DW-1:0] V_TIMED  = 16'hCFE8;
endpackage

// File: rtl/kwd_keys.sv
module kwd_keys
    import kwd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          cmd_feed,
    output logic          cmd_restart,
    output logic          cmd_disable,
    output logic          cmd_stat_clr,
    output logic          armed_q
);
    logic key1_hit;

    always_comb begin
        key1_hit     = wr_en && (addr == A_DIS1) && (wdata == K_DIS1);
        cmd_feed     = wr_en && (addr == A_FEED) && (wdata == K_FEED);
        cmd_restart  = wr_en && (addr == A_RSTRT) && (wdata == K_RSTRT);
        cmd_disable  = wr_en && (addr == A_DIS2) && (wdata == K_DIS2) && armed_q;
        cmd_stat_clr = wr_en && (addr == A_STAT) && (wdata == K_SCLR);
    end

    // any write re-decides the arming; only the first key leaves it set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (wr_en) armed_q <= key1_hit;
    end
endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_ok,
    input  logic          cmd_feed,
    input  logic          cmd_restart,
    input  logic          cmd_disable,
    input  logic [CW-1:0] tmo_val,
    output wd_state_e     state_q,
    output logic [CW-1:0] cnt_q,
    output logic          upd_q,
    output logic          warn,
    output logic          expire,
    output logic          rst_pulse_q
);
    wd_state_e state_d;
    logic      step;
    logic      load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (cmd_restart) state_d = ST_READY;
            ST_READY: if (cmd_disable) state_d = ST_OFF;
                      else if (cmd_feed) state_d = ST_RUN;
            ST_RUN:   if (cmd_disable) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        load   = cmd_feed && !cmd_disable && (state_q != ST_OFF);
        step   = (state_q == ST_RUN) && tick_ok && !cmd_feed && !cmd_disable;
        expire = step && (cnt_q == '0);
        warn   = step && (cnt_q == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            upd_q       <= 1'b0;
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= expire;
            upd_q       <= load || step;
            if (load || expire) cnt_q <= tmo_val;
            else if (step)      cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/kwd_irq.sv
module kwd_irq
    import kwd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          wbit0,
    input  logic          warn,
    output logic          event_q,
    output logic          mask_q,
    output logic          irq
);
    logic set_ev;
    logic ack_ev;

    always_comb begin
        set_ev = warn || (wr_en && (addr == A_FORCE) && wbit0);
        ack_ev = wr_en && (addr == A_EVT) && wbit0;
        irq    = event_q && mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            if (set_ev)      event_q <= 1'b1;
            else if (ack_ev) event_q <= 1'b0;
            if (wr_en && (addr == A_MASK)) mask_q <= wbit0;
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int          CW          = 15,
    parameter logic [14:0] DEF_TIMEOUT = 15'd6000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          dbg_mode,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          wdog_rst
);
    localparam int PADW = DW - CW - 1;

    wd_state_e     fsm_state;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] tmo_q;
    logic          upd_q, warn, expire;
    logic          cmd_feed, cmd_restart, cmd_disable, cmd_stat_clr, armed_q;
    logic          event_q, irq_mask_q;
    logic          stat_q, keep_q, tick_ok;

    kwd_keys u_keys (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cmd_feed(cmd_feed), .cmd_restart(cmd_restart), .cmd_disable(cmd_disable),
        .cmd_stat_clr(cmd_stat_clr), .armed_q(armed_q)
    );

    assign tick_ok = tick_en && (!dbg_mode || keep_q);

    kwd_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_ok(tick_ok), .cmd_feed(cmd_feed),
        .cmd_restart(cmd_restart), .cmd_disable(cmd_disable), .tmo_val(tmo_q),
        .state_q(fsm_state), .cnt_q(cnt_q), .upd_q(upd_q), .warn(warn),
        .expire(expire), .rst_pulse_q(wdog_rst)
    );

    kwd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wbit0(bus_wdata[0]),
        .warn(warn), .event_q(event_q), .mask_q(irq_mask_q), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q  <= DEF_TIMEOUT[CW-1:0];
            stat_q <= 1'b0;
            keep_q <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == A_TMO)) tmo_q  <= bus_wdata[CW-1:0];
            if (bus_wr && (bus_addr == A_DBG)) keep_q <= bus_wdata[0];
            if (expire)            stat_q <= 1'b1;
            else if (cmd_stat_clr) stat_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_TMO:   bus_rdata = {{(DW-CW){1'b0}}, tmo_q};
            A_DIS2:  bus_rdata = (fsm_state == ST_OFF) ? V_OFF : '0;
            A_STAT:  bus_rdata = stat_q ? V_TIMED : '0;
            A_CNT:   bus_rdata = {upd_q, {PADW{1'b0}}, cnt_q};
            A_DBG:   bus_rdata = {{(DW-2){1'b0}}, dbg_mode, keep_q};
            A_EVT:   bus_rdata = {{(DW-1){1'b0}}, event_q};
            A_MASK:  bus_rdata = {{(DW-1){1'b0}}, irq_mask_q};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int CW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wdog_rst,
    input logic          irq,
    input logic          mask_bit,
    input logic          stat_bit,
    input logic          is_off,
    input logic          armed,
    input logic [CW-1:0] cnt
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    a_r8_status_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> stat_bit);

    a_r9_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_bit |-> !irq);

    a_r5_off_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_off) |-> $past(armed));

    a_r5_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_off) |-> $stable(cnt));
endmodule

bind keyed_wdog kwd_checker #(.CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .wdog_rst(wdog_rst), .irq(irq),
    .mask_bit(irq_mask_q), .stat_bit(stat_q), .is_off(fsm_state == kwd_pkg::ST_OFF),
    .armed(armed_q), .cnt(cnt_q)
);

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, wdog_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_mode(dbg_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 28;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 6'h0C, 16'h0000, 16'hDABE},  // R1/R3 off after reset
        {1'b0, 6'h04, 16'h0000, 16'h1770},  // R1 default timeout
        {1'b1, 6'h04, 16'h0003, 16'h0000},
        {1'b0, 6'h04, 16'h0000, 16'h0003},  // R2
        {1'b1, 6'h04, 16'hFFFF, 16'h0000},
        {1'b0, 6'h04, 16'h0000, 16'h7FFF},  // R2 15 bits
        {1'b1, 6'h04, 16'h0003, 16'h0000},
        {1'b1, 6'h00, 16'hFEED, 16'h0000},  // R4 feed while off
        {1'b0, 6'h14, 16'h0000, 16'h0000},
        {1'b1, 6'h1C, 16'h1234, 16'h0000},  // R3 wrong key
        {1'b0, 6'h0C, 16'h0000, 16'hDABE},
        {1'b1, 6'h1C, 16'hACED, 16'h0000},  // R3 restart
        {1'b0, 6'h0C, 16'h0000, 16'h0000},
        {1'b1, 6'h00, 16'h1234, 16'h0000},  // R4 wrong feed key
        {1'b0, 6'h14, 16'h0000, 16'h0000},
        {1'b1, 6'h00, 16'hFEED, 16'h0000},  // R4 feed
        {1'b0, 6'h14, 16'h0000, 16'h8003},  // R6 update flag
        {1'b0, 6'h14, 16'h0000, 16'h0003},
        {1'b1, 6'h28, 16'h0001, 16'h0000},  // R9 force
        {1'b0, 6'h20, 16'h0000, 16'h0001},
        {1'b1, 6'h20, 16'h0001, 16'h0000},  // R9 ack
        {1'b0, 6'h20, 16'h0000, 16'h0000},
        {1'b1, 6'h24, 16'h0001, 16'h0000},
        {1'b0, 6'h24, 16'h0000, 16'h0001},  // R9 mask
        {1'b1, 6'h18, 16'h0001, 16'h0000},
        {1'b0, 6'h18, 16'h0000, 16'h0001},  // R10 keep bit
        {1'b1, 6'h18, 16'h0000, 16'h0000},
        {1'b0, 6'h10, 16'h0000, 16'h0000}   // R8 normal status
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [15:0] exp);
        bus_addr = a;
        #2 chk(req, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(posedge clk); @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wdog_rst", {15'd0, wdog_rst}, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][38]) wr(VEC[i][37:32], VEC[i][31:16]);
            else rd("R1-table", VEC[i][37:32], VEC[i][15:0]);
        end
        // countdown, warning, expiry (R6, R7, R8)
        tick();
        rd("R6 count", 6'h14, 16'h8002);
        tick(); tick();
        chk("R7 warn irq", {15'd0, irq}, 16'h0001);
        chk("R7 no rst yet", {15'd0, wdog_rst}, 16'h0000);
        rd("R7 event", 6'h20, 16'h0001);
        tick();
        chk("R7 rst pulse", {15'd0, wdog_rst}, 16'h0001);
        rd("R8 timed out", 6'h10, 16'hCFE8);
        chk("R7 rst one cycle", {15'd0, wdog_rst}, 16'h0000);
        rd("R7 reload", 6'h14, 16'h0003);
        wr(6'h20, 16'h0001);
        chk("R9 ack irq", {15'd0, irq}, 16'h0000);
        wr(6'h10, 16'h1234);
        rd("R8 wrong clear key", 6'h10, 16'hCFE8);
        wr(6'h10, 16'hE8B4);
        rd("R8 cleared", 6'h10, 16'h0000);
        // debug hold (R10)
        dbg_mode = 1'b1;
        rd("R10 dbg flag", 6'h18, 16'h0002);
        tick();
        rd("R10 held", 6'h14, 16'h0003);
        wr(6'h18, 16'h0001);
        rd("R10 keep", 6'h18, 16'h0003);
        tick();
        rd("R10 keep runs", 6'h14, 16'h8002);
        wr(6'h18, 16'h0000);
        dbg_mode = 1'b0;
        // disable sequence (R5)
        wr(6'h08, 16'h0BAD);
        wr(6'h04, 16'h0003);
        wr(6'h0C, 16'hCAFE);
        rd("R5 disarmed", 6'h0C, 16'h0000);
        wr(6'h08, 16'h0BAD);
        wr(6'h0C, 16'hCAFE);
        rd("R5 disabled", 6'h0C, 16'hDABE);
        tick();
        rd("R5 frozen", 6'h14, 16'h0002);
        wr(6'h00, 16'hFEED);
        rd("R4 feed off", 6'h14, 16'h0002);
        // force with mask off (R9)
        wr(6'h24, 16'h0000);
        wr(6'h28, 16'h0001);
        chk("R9 masked", {15'd0, irq}, 16'h0000);
        rd("R9 forced event", 6'h20, 16'h0001);
        // reset again (R1)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 timeout", 6'h04, 16'h1770);
        rd("R1 off", 6'h0C, 16'hDABE);
        rd("R1 event", 6'h20, 16'h0000);
        rd("R1 count", 6'h14, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule